// File: doc/BRIEF.md
# Triggered Register-Replay Engine

This block plays back a list of register writes held in memory. Each list entry is a pair of 32-bit words: a target register address and the value to write there. Software programs a start byte address and the byte address of the list's last byte. It then picks the event that begins a run: a manual kick, a vertical-sync pulse, or a match between the incoming line count and a programmed line number. When that event occurs, the engine walks the list in order. It reads each pair through a single-outstanding memory read port and issues the pair as one write on a register-bus master port.

After a run finishes, the engine raises a done flag that also drives an interrupt line. It then waits for the next event of the selected kind. Selecting the stop code disarms the engine, and selecting it during a run ends that run early. A malformed span is rejected before any write is issued, and an error flag is raised. A soft-reset bit returns the engine to idle at once.

Top module: `reg_replay_dma`

## Requirements
- R1: Each entry is 8 bytes. The word at the entry's base byte address is the register address and the word at base+4 is the value. The engine issues one bus write with that address and value, holding `bus_wr`, `bus_addr` and `bus_wdata` steady until `bus_ack`.
- R2: A run over start S and end E issues exactly (E-S+1)/8 writes, in increasing entry order.
- R3: MODE (config index 1) bits [1:0] select the trigger: 00 stop (nothing starts a run), 01 manual (writing 1 to CTRL bit 2 starts a run), 10 rising edge of `vsync`, 11 the cycle in which `line_cnt` becomes equal to the LINE register (index 4). An event that is not of the selected kind starts nothing.
- R4: Trigger events that arrive while a run is in progress are ignored.
- R5: After a run completes, the engine starts a further run on the next event of the selected kind.
- R6: Writing a stop code into MODE during a run ends the run. At most one further bus write completes after the MODE write, and done stays clear.
- R7: A run is rejected, with no memory reads and no writes, and STATUS bit 1 (error) is set in the following cases: E < S, (E-S+1) is not a multiple of 8, or the list holds more than 512 entries.
- R8: MODE bit 3 set (address increment) makes entry k write to A0+4k, where A0 is the first entry's address word. MODE bit 3 clear makes each entry write to its own address word.
- R9: MODE bit 2 is the write flag. If it is clear when a run would start, the run is rejected as in R7.
- R10: At most one memory read is outstanding. `mem_req` and `mem_addr` hold until `mem_rvalid`, and `mem_req` and `bus_wr` are never high together.
- R11: Completion sets STATUS bit 0 (done) and `irq`. Writing 1 to CTRL bit 1 clears done, error and `irq`.
- R12: Writing 1 to CTRL bit 0 (soft reset) stops any run in the next cycle and clears busy (STATUS bit 2), done and error.
- R13: After `rst_n` is released, STATUS reads 0 and `irq`, `mem_req` and `bus_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_addr | input | 3 | Config register index (0 CTRL, 1 MODE, 2 START, 3 END, 4 LINE, 5 STATUS) |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for `cfg_addr` (combinational) |
| vsync | input | 1 | Vertical-sync event input |
| line_cnt | input | 12 | Current line number |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Memory read response valid |
| mem_rdata | input | 32 | Memory read data |
| bus_wr | output | 1 | Register-bus write request, held until ack |
| bus_addr | output | 32 | Register-bus target address |
| bus_wdata | output | 32 | Register-bus write data |
| bus_ack | input | 1 | Register-bus write acknowledge |
| irq | output | 1 | Completion interrupt (mirrors done) |

## Verification
On every cycle, the assertions check the handshake rules: a held read request, a held write, no overlap of the memory and bus ports, and done rising only on a final acknowledge. They also check that an error is raised only while nothing is in flight. The bench's scenarios are needed for the rest. These are the order and content of the replayed writes, the span checks at the 512-entry edge, and the trigger selection with its re-arm. They also cover ignoring events mid-run, stopping early, and soft reset.

// File: rtl/rr_pkg.sv
// Shared types for the register-replay engine.
// Assumes config index map: 0 CTRL, 1 MODE, 2 START, 3 END, 4 LINE, 5 STATUS.
package rr_pkg;
    typedef enum logic [1:0] {
        TRIG_STOP   = 2'b00,
        TRIG_MANUAL = 2'b01,
        TRIG_VSYNC  = 2'b10,
        TRIG_LINE   = 2'b11
    } trig_e;

    typedef struct packed {
        logic  inc_en;
        logic  wr_en;
        trig_e trig;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GET_ADDR,
        ST_GET_VAL,
        ST_WRITE
    } state_e;

    localparam logic [2:0] IDX_CTRL   = 3'd0;
    localparam logic [2:0] IDX_MODE   = 3'd1;
    localparam logic [2:0] IDX_START  = 3'd2;
    localparam logic [2:0] IDX_END    = 3'd3;
    localparam logic [2:0] IDX_LINE   = 3'd4;
    localparam logic [2:0] IDX_STATUS = 3'd5;
endpackage

// File: rtl/rr_cfg_regs.sv
// Config register file: holds mode, list bounds and line number, and turns
// CTRL writes into one-cycle pulses. Assumes writes are single-cycle strobes.
module rr_cfg_regs
    import rr_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          st_done,
    input  logic          st_err,
    input  logic          st_busy,
    output mode_t         mode,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] end_addr,
    output logic [LW-1:0] line_match,
    output logic          sw_rst,
    output logic          irq_clr,
    output logic          kick
);
    logic ctrl_wr;

    // Decode CTRL strobes.
    always_comb begin
        ctrl_wr = cfg_we && (cfg_addr == IDX_CTRL);
        sw_rst  = ctrl_wr && cfg_wdata[0];
        irq_clr = ctrl_wr && cfg_wdata[1];
        kick    = ctrl_wr && cfg_wdata[2];
    end

    // Store the persistent configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= '0;
            start_addr <= '0;
            end_addr   <= '0;
            line_match <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                IDX_MODE:  mode       <= mode_t'(cfg_wdata[3:0]);
                IDX_START: start_addr <= cfg_wdata[AW-1:0];
                IDX_END:   end_addr   <= cfg_wdata[AW-1:0];
                IDX_LINE:  line_match <= cfg_wdata[LW-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            IDX_MODE:   cfg_rdata[3:0]    = mode;
            IDX_START:  cfg_rdata[AW-1:0] = start_addr;
            IDX_END:    cfg_rdata[AW-1:0] = end_addr;
            IDX_LINE:   cfg_rdata[LW-1:0] = line_match;
            IDX_STATUS: cfg_rdata[2:0]    = {st_busy, st_err, st_done};
            default: ;
        endcase
    end
endmodule

// File: rtl/rr_trigger.sv
// Trigger selection: produces a one-cycle start pulse from the selected event
// source. Assumes vsync and line_cnt are synchronous to clk.
module rr_trigger
    import rr_pkg::*;
#(
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  trig_e         sel,
    input  logic          kick,
    input  logic          vsync,
    input  logic [LW-1:0] line_cnt,
    input  logic [LW-1:0] line_match,
    output logic          fire
);
    logic vs_q, eq_q, eq_now;

    assign eq_now = (line_cnt == line_match);

    // Remember previous event levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q <= 1'b0;
            eq_q <= 1'b0;
        end else begin
            vs_q <= vsync;
            eq_q <= eq_now;
        end
    end

    // Pick the event of the selected kind.
    always_comb begin
        case (sel)
            TRIG_MANUAL: fire = kick;
            TRIG_VSYNC:  fire = vsync && !vs_q;
            TRIG_LINE:   fire = eq_now && !eq_q;
            default:     fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/rr_engine.sv
// Replay sequencer: validates the span, fetches each (address, value) pair with
// one read outstanding, issues it as a bus write, and handles stop and done.
// Assumes mem_rvalid answers the held request; stray responses in idle are dropped.
module rr_engine
    import rr_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int MAX_DESC = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_rst,
    input  logic          fire,
    input  mode_t         mode,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    input  logic          irq_clr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          bus_wr,
    output logic [DW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    output logic          busy,
    output logic          done,
    output logic          err
);
    localparam int RW      = $clog2(MAX_DESC) + 1;
    localparam int MAX_SPN = MAX_DESC * 8;

    state_e        state;
    logic [AW-1:0] ptr;
    logic [RW-1:0] rem, idx;
    logic [DW-1:0] d_addr, d_val, base;
    logic          inc_q, stop_req, span_ok;
    logic [AW:0]   span;

    assign stop_req = (mode.trig == TRIG_STOP);

    // Span check: ordered bounds, whole entries, list fits, write flag set.
    always_comb begin
        span    = {1'b0, end_addr} - {1'b0, start_addr} + 1'b1;
        span_ok = (end_addr >= start_addr) && (span[2:0] == 3'b000)
               && (span <= (AW+1)'(MAX_SPN)) && mode.wr_en;
    end

    // Port outputs derived from the state.
    always_comb begin
        busy      = (state != ST_IDLE);
        mem_req   = (state == ST_GET_ADDR) || (state == ST_GET_VAL);
        mem_addr  = (state == ST_GET_VAL) ? ptr + AW'(4) : ptr;
        bus_wr    = (state == ST_WRITE);
        bus_wdata = d_val;
        bus_addr  = inc_q ? base + (DW'(idx) << 2) : d_addr;
    end

    // Sequencer state, list pointer and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            rem    <= '0;
            idx    <= '0;
            d_addr <= '0;
            d_val  <= '0;
            base   <= '0;
            inc_q  <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (irq_clr) begin
                done <= 1'b0;
                err  <= 1'b0;
            end
            case (state)
                ST_IDLE: if (fire) begin
                    if (span_ok) begin
                        ptr   <= start_addr;
                        rem   <= span[RW+2:3];
                        idx   <= '0;
                        inc_q <= mode.inc_en;
                        state <= ST_GET_ADDR;
                    end else begin
                        err <= 1'b1;
                    end
                end
                ST_GET_ADDR: if (mem_rvalid) begin
                    if (stop_req) state <= ST_IDLE;
                    else begin
                        d_addr <= mem_rdata;
                        if (idx == '0) base <= mem_rdata;
                        state <= ST_GET_VAL;
                    end
                end
                ST_GET_VAL: if (mem_rvalid) begin
                    if (stop_req) state <= ST_IDLE;
                    else begin
                        d_val <= mem_rdata;
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: if (bus_ack) begin
                    if (rem == RW'(1)) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (stop_req) begin
                        state <= ST_IDLE;
                    end else begin
                        ptr   <= ptr + AW'(8);
                        rem   <= rem - 1'b1;
                        idx   <= idx + 1'b1;
                        state <= ST_GET_ADDR;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: the read and write ports are never active together.
    p_one_port_r10: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        !(mem_req && bus_wr));

    // R10: a read request holds its address until answered.
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R1: a bus write holds address and data until acknowledged.
    p_wr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (bus_wr && !bus_ack) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

    // R11: done rises only right after an acknowledged write.
    p_done_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        $rose(done) |-> $past(bus_wr && bus_ack));

    // R7: a rejected run leaves nothing in flight.
    p_err_no_run_r7: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        $rose(err) |-> (!busy && !mem_req && !bus_wr));
endmodule

// File: rtl/reg_replay_dma.sv
// Top of the register-replay engine: config registers, trigger selection and
// the replay sequencer. Assumes one clock domain and synchronous active-low reset.
module reg_replay_dma
    import rr_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int LW       = 12,
    parameter int MAX_DESC = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          vsync,
    input  logic [LW-1:0] line_cnt,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          bus_wr,
    output logic [DW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    output logic          irq
);
    mode_t         mode;
    logic [AW-1:0] start_addr, end_addr;
    logic [LW-1:0] line_match;
    logic          sw_rst, irq_clr, kick, fire, busy, done, err;

    rr_cfg_regs #(.AW(AW), .LW(LW)) u_regs (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .st_done(done), .st_err(err), .st_busy(busy),
        .mode, .start_addr, .end_addr, .line_match,
        .sw_rst, .irq_clr, .kick
    );

    rr_trigger #(.LW(LW)) u_trig (
        .clk, .rst_n, .sel(mode.trig), .kick, .vsync, .line_cnt,
        .line_match, .fire
    );

    rr_engine #(.AW(AW), .DW(DW), .MAX_DESC(MAX_DESC)) u_eng (
        .clk, .rst_n, .sw_rst, .fire, .mode, .start_addr, .end_addr, .irq_clr,
        .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
        .bus_wr, .bus_addr, .bus_wdata, .bus_ack,
        .busy, .done, .err
    );

    assign irq = done;
endmodule

// File: tb/sim_reg_replay_dma.sv
module sim_reg_replay_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        vsync = 1'b0;
    logic [11:0] line_cnt = '0;
    logic        mem_req, bus_wr, irq;
    logic [31:0] mem_addr, bus_addr, bus_wdata;
    logic        mem_rvalid, bus_ack;
    logic [31:0] mem_rdata;

    int checks = 0;
    int fails  = 0;
    int lc     = 0;
    logic [31:0] log_a [1024];
    logic [31:0] log_d [1024];

    always #2.5 clk = ~clk;

    reg_replay_dma u0 (.*);

    function automatic logic [31:0] mem_model(logic [31:0] a);
        return a[2] ? (a ^ 32'h5A5A_0000) : (32'hC000_0000 | a);
    endfunction

    // Memory and register-bus responders plus write log.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            bus_ack    <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_req && !mem_rvalid;
            mem_rdata  <= mem_model(mem_addr);
            bus_ack    <= bus_wr && !bus_ack;
            if (bus_wr && bus_ack) begin
                log_a[lc % 1024] <= bus_addr;
                log_d[lc % 1024] <= bus_wdata;
                lc <= lc + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_status(output logic [31:0] v);
        @(negedge clk);
        cfg_addr = 3'd5;
        #1 v = cfg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        rd_status(s);
        while (s[2]) rd_status(s);
    endtask

    task automatic pulse_vsync();
        @(negedge clk); vsync = 1'b1;
        @(negedge clk); @(negedge clk); vsync = 1'b0;
    endtask

    // Compare logged writes from index b onward against the expected list.
    task automatic chk_list(input string req, input int b, input int n,
                            input logic [31:0] s, input bit inc);
        int bad = -1;
        for (int k = 0; k < n; k++) begin
            logic [31:0] ea, ed;
            ea = inc ? (32'hC000_0000 | s) + 32'(4 * k) : (32'hC000_0000 | (s + 32'(8 * k)));
            ed = (s + 32'(8 * k) + 32'd4) ^ 32'h5A5A_0000;
            if (bad < 0 && (log_a[(b + k) % 1024] !== ea || log_d[(b + k) % 1024] !== ed))
                bad = k;
        end
        chk(bad < 0, req, "entry content/order (first bad index)", bad, -1);
    endtask

    // start, end, mode, writes, err, done
    localparam bit [85:0] VEC [8] = '{
        {32'h100, 32'h107,  4'h5, 16'd1,   1'b0, 1'b1},
        {32'h200, 32'h21F,  4'h5, 16'd4,   1'b0, 1'b1},
        {32'h300, 32'h3FF,  4'hD, 16'd32,  1'b0, 1'b1},
        {32'h100, 32'h0F0,  4'h5, 16'd0,   1'b1, 1'b0},
        {32'h100, 32'h10B,  4'h5, 16'd0,   1'b1, 1'b0},
        {32'h000, 32'hFFF,  4'h5, 16'd512, 1'b0, 1'b1},
        {32'h000, 32'h1007, 4'h5, 16'd0,   1'b1, 1'b0},
        {32'h400, 32'h40F,  4'h1, 16'd0,   1'b1, 1'b0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] st;
        int b, b2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_status(st);
        // R13: reset state
        chk(st == 0, "R13", "status after reset", st, 0);
        chk(!irq && !mem_req && !bus_wr, "R13", "irq/mem_req/bus_wr after reset",
            {irq, mem_req, bus_wr}, 0);

        // Table walk: R1 R2 R7 R8 R9 R11
        foreach (VEC[i]) begin
            logic [31:0] s, e; logic [3:0] m; logic [15:0] n; bit xe, xd;
            {s, e, m, n, xe, xd} = VEC[i];
            wr(3'd0, 32'h2);
            wr(3'd2, s); wr(3'd3, e); wr(3'd1, {28'd0, m});
            b = lc;
            wr(3'd0, 32'h4);
            wait_idle();
            repeat (3) @(negedge clk);
            rd_status(st);
            chk(lc - b == int'(n), (xe ? (m[2] ? "R7" : "R9") : "R2"), "write count", lc - b, n);
            chk(st[1] == xe, (m[2] ? "R7" : "R9"), "error bit", st[1], xe);
            chk(st[0] == xd && irq == xd, "R11", "done/irq", {st[0], irq}, {xd, xd});
            if (n != 0) chk_list(m[3] ? "R8" : "R1", b, int'(n), s, m[3]);
        end

        // R11: clear done
        wr(3'd0, 32'h2);
        rd_status(st);
        chk(st[1:0] == 0 && !irq, "R11", "done/err cleared", st, 0);

        // R3: manual kick ignored in vsync mode; vsync starts run. R4/R5 re-arm.
        wr(3'd2, 32'h300); wr(3'd3, 32'h3FF); wr(3'd1, 32'h6);
        b = lc;
        wr(3'd0, 32'h4);
        repeat (10) @(negedge clk);
        chk(lc == b, "R3", "kick in vsync mode writes", lc - b, 0);
        pulse_vsync();
        repeat (20) @(negedge clk);
        pulse_vsync();
        wr(3'd0, 32'h4);
        pulse_vsync();
        wait_idle();
        repeat (3) @(negedge clk);
        chk(lc - b == 32, "R4", "writes with triggers mid-run", lc - b, 32);
        chk_list("R3", b, 32, 32'h300, 1'b0);
        b = lc;
        pulse_vsync();
        wait_idle();
        repeat (3) @(negedge clk);
        chk(lc - b == 32, "R5", "re-armed second run", lc - b, 32);

        // R3: line-match trigger fires once on equality
        wr(3'd0, 32'h2);
        wr(3'd2, 32'h200); wr(3'd3, 32'h21F); wr(3'd4, 32'd5); wr(3'd1, 32'h7);
        b = lc;
        for (int l = 0; l < 10; l++) begin @(negedge clk); line_cnt = 12'(l); end
        wait_idle();
        repeat (3) @(negedge clk);
        rd_status(st);
        chk(lc - b == 4 && st[0], "R3", "line-match run writes/done", lc - b, 4);

        // R3: stop mode ignores kick and vsync
        wr(3'd0, 32'h2);
        wr(3'd1, 32'h4);
        b = lc;
        wr(3'd0, 32'h4);
        pulse_vsync();
        repeat (10) @(negedge clk);
        rd_status(st);
        chk(lc == b && st == 0, "R3", "stop mode writes/status", lc - b, 0);

        // R6: stop during run
        wr(3'd2, 32'h300); wr(3'd3, 32'h3FF); wr(3'd1, 32'h5);
        b = lc;
        wr(3'd0, 32'h4);
        while (lc - b < 3) @(negedge clk);
        wr(3'd1, 32'h4);
        b2 = lc;
        wait_idle();
        repeat (5) @(negedge clk);
        rd_status(st);
        chk(lc - b2 <= 1, "R6", "writes after stop", lc - b2, 1);
        chk(lc - b < 32 && !st[0], "R6", "run cut short, no done", lc - b, 32);

        // R12: soft reset mid-run
        wr(3'd1, 32'h5);
        b = lc;
        wr(3'd0, 32'h4);
        while (lc - b < 2) @(negedge clk);
        wr(3'd0, 32'h1);
        b2 = lc;
        rd_status(st);
        chk(st == 0 && !bus_wr && !mem_req, "R12", "status/ports after soft reset",
            {st[2:0], bus_wr, mem_req}, 0);
        repeat (10) @(negedge clk);
        chk(lc == b2, "R12", "no writes after soft reset", lc - b2, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule